// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small accumulator datapath. It holds an 8-bit working register (W) and, on each accepted operation, combines W with a second operand. That operand is taken either from a file-register read bus or from an immediate value carried by the instruction. The 8-bit result is written back to W, or it is presented on a file write port for one cycle. Three status flags are kept in the block: Carry, Digit Carry (the carry out of the low nibble) and Zero.

Each operation code has a mask that selects which flags it updates. Flags outside the mask keep their previous values. For subtraction, Carry and Digit Carry report the absence of a borrow, so they are inverted borrow outs of bit 7 and bit 3. The two rotates pass the outgoing bit through Carry. Instruction decoding, address generation and mapping the flags into a status register are left to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, W, Carry, Digit Carry and Zero clear to 0 and `file_we` is 0 in the following cycle.
- R2: Code 0 (add) produces B+W. Carry is the carry out of bit 7, Digit Carry is the carry from bit 3 into bit 4, and Zero is set when the 8-bit result is 0x00.
- R3: Code 1 (subtract) produces B-W as B + ~W + 1. Carry is 1 when B >= W (no borrow), Digit Carry is 1 when B[3:0] >= W[3:0], and Zero follows the result.
- R4: Codes 2 (AND), 3 (OR) and 4 (XOR) combine B with W and update only Zero. Carry and Digit Carry are held.
- R5: Code 9 (rotate left) produces {B[6:0], C} and loads B[7] into Carry. Code 10 (rotate right) produces {C, B[7:1]} and loads B[0] into Carry. Zero and Digit Carry are held.
- R6: The single-operand codes 5 (pass B), 6 (complement B), 7 (B+1), 8 (B-1) and 12 (clear to 0x00) update only Zero.
- R7: Code 11 (swap nibbles of B) updates no flag.
- R8: When `dst_sel`=0, the result is written to W and `file_we` stays 0. When `dst_sel`=1, `file_we` pulses high for one cycle with the result on `file_wdata`, and W is unchanged.
- R9: B is `imm_data` when `src_sel`=1 and `file_rdata` when `src_sel`=0.
- R10: A cycle with `op_valid`=0 changes neither W nor any flag, and it raises no `file_we`.
- R11: Codes 13, 14 and 15 are reserved. They change neither W nor any flag, and they raise no `file_we`, even with `op_valid`=1.
- R12: Every result is registered. W, the flags, `file_we` and `file_wdata` show an operation's effect in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| src_sel | input | 1 | 1: immediate operand, 0: file operand |
| dst_sel | input | 1 | 0: result to W, 1: result to file port |
| file_rdata | input | 8 | File-register operand |
| imm_data | input | 8 | Immediate operand |
| w_out | output | 8 | Working register contents |
| flag_c | output | 1 | Carry / not-borrow |
| flag_dc | output | 1 | Digit Carry / nibble not-borrow |
| flag_z | output | 1 | Zero |
| file_wdata | output | 8 | Result bound for the file |
| file_we | output | 1 | One-cycle write strobe for file_wdata |

## Verification
An operation is accepted on a rising edge. W, the three flags and the file write strobe all come from a single register stage, so every effect is due exactly one cycle later. The bench drives inputs on the falling edge and samples on the next falling edge, which falls half a period after the accepting edge. One further falling edge later it checks that the file strobe has dropped again, because each write must last a single cycle. Flag values that must be held are carried over from earlier scenarios, so each expected value depends on the sequence that came before it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int FLAG_N = 3;

    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [FLAG_N-1:0] flagvec_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_IOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_PASS = 4'd5,
        OP_COM  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_RLC  = 4'd9,
        OP_RRC  = 4'd10,
        OP_SWAP = 4'd11,
        OP_CLR  = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } alu_op_e;

    typedef struct packed {
        word_t    res;
        flagvec_t flg;
        flagvec_t mask;
    } alu_out_t;

    function automatic logic op_defined(alu_op_e op);
        return op <= OP_CLR;
    endfunction

    function automatic flagvec_t flag_mask(alu_op_e op);
        flagvec_t m;
        m = '0;
        case (op)
            OP_ADD, OP_SUB: m = '1;
            OP_AND, OP_IOR, OP_XOR,
            OP_PASS, OP_COM, OP_INC,
            OP_DEC, OP_CLR: m[FLG_Z] = 1'b1;
            OP_RLC, OP_RRC: m[FLG_C] = 1'b1;
            default:        m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  alu_op_e  op,
    input  word_t    a_w,
    input  word_t    b_opnd,
    input  logic     c_in,
    output alu_out_t out
);
    logic [DATA_W:0] add_full;
    logic [DATA_W:0] sub_full;
    logic [NIB_W:0]  add_nib;
    logic [NIB_W:0]  sub_nib;
    word_t           res;
    logic            c_new;
    logic            dc_new;

    always_comb begin
        add_full = {1'b0, b_opnd} + {1'b0, a_w};
        sub_full = {1'b0, b_opnd} + {1'b0, ~a_w} + {{DATA_W{1'b0}}, 1'b1};
        add_nib  = {1'b0, b_opnd[NIB_W-1:0]} + {1'b0, a_w[NIB_W-1:0]};
        sub_nib  = {1'b0, b_opnd[NIB_W-1:0]} + {1'b0, ~a_w[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, 1'b1};
        res    = b_opnd;
        c_new  = c_in;
        dc_new = 1'b0;
        case (op)
            OP_ADD:  begin res = add_full[DATA_W-1:0]; c_new = add_full[DATA_W]; dc_new = add_nib[NIB_W]; end
            OP_SUB:  begin res = sub_full[DATA_W-1:0]; c_new = sub_full[DATA_W]; dc_new = sub_nib[NIB_W]; end
            OP_AND:  res = b_opnd & a_w;
            OP_IOR:  res = b_opnd | a_w;
            OP_XOR:  res = b_opnd ^ a_w;
            OP_PASS: res = b_opnd;
            OP_COM:  res = ~b_opnd;
            OP_INC:  res = b_opnd + word_t'(1);
            OP_DEC:  res = b_opnd - word_t'(1);
            OP_RLC:  begin res = {b_opnd[DATA_W-2:0], c_in}; c_new = b_opnd[DATA_W-1]; end
            OP_RRC:  begin res = {c_in, b_opnd[DATA_W-1:1]}; c_new = b_opnd[0]; end
            OP_SWAP: res = {b_opnd[NIB_W-1:0], b_opnd[DATA_W-1:NIB_W]};
            OP_CLR:  res = '0;
            default: res = b_opnd;
        endcase
        out.res         = res;
        out.flg[FLG_C]  = c_new;
        out.flg[FLG_DC] = dc_new;
        out.flg[FLG_Z]  = (res == '0);
        out.mask        = flag_mask(op);
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  flagvec_t mask,
    input  flagvec_t nxt,
    output flagvec_t q
);
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (en && mask[i])
                q[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic       src_sel,
    input  logic       dst_sel,
    input  logic [7:0] file_rdata,
    input  logic [7:0] imm_data,
    output logic [7:0] w_out,
    output logic       flag_c,
    output logic       flag_dc,
    output logic       flag_z,
    output logic [7:0] file_wdata,
    output logic       file_we
);
    alu_op_e  op;
    word_t    w_q;
    word_t    b_opnd;
    alu_out_t core_out;
    flagvec_t flg_q;
    logic     take;

    assign op     = alu_op_e'(op_code);
    assign b_opnd = src_sel ? imm_data : file_rdata;
    assign take   = op_valid && op_defined(op);

    acc_alu_core u_core (
        .op     (op),
        .a_w    (w_q),
        .b_opnd (b_opnd),
        .c_in   (flg_q[FLG_C]),
        .out    (core_out)
    );

    acc_alu_flags u_flags (
        .clk  (clk),
        .rst  (rst),
        .en   (take),
        .mask (core_out.mask),
        .nxt  (core_out.flg),
        .q    (flg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q        <= '0;
            file_we    <= 1'b0;
            file_wdata <= '0;
        end else begin
            file_we <= take && dst_sel;
            if (take && !dst_sel)
                w_q <= core_out.res;
            if (take && dst_sel)
                file_wdata <= core_out.res;
        end
    end

    assign w_out   = w_q;
    assign flag_c  = flg_q[FLG_C];
    assign flag_dc = flg_q[FLG_DC];
    assign flag_z  = flg_q[FLG_Z];
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [3:0] op_code,
    input logic       src_sel,
    input logic       dst_sel,
    input logic [7:0] file_rdata,
    input logic [7:0] imm_data,
    input logic [7:0] w_out,
    input logic       flag_c,
    input logic       flag_dc,
    input logic       flag_z,
    input logic       file_we
);
    logic [7:0] b_sel;
    logic       is_logic;
    logic       is_rot;
    assign b_sel    = src_sel ? imm_data : file_rdata;
    assign is_logic = op_code == OP_AND || op_code == OP_IOR || op_code == OP_XOR;
    assign is_rot   = op_code == OP_RLC || op_code == OP_RRC;

    p_we_src_r8: assert property (@(posedge clk) disable iff (rst)
        file_we |-> $past(op_valid) && $past(dst_sel));

    p_dst_file_keeps_w_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid && dst_sel |=> $stable(w_out));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(w_out) && $stable(flag_c) && $stable(flag_dc)
                      && $stable(flag_z) && !file_we);

    p_reserved_hold_r11: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code > OP_CLR |=> $stable(w_out) && $stable(flag_c) && !file_we);

    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_SUB |=> flag_c == ($past(b_sel) >= $past(w_out)));

    p_logic_keeps_c_r4: assert property (@(posedge clk) disable iff (rst)
        op_valid && is_logic |=> $stable(flag_c) && $stable(flag_dc));

    p_rot_keeps_z_r5: assert property (@(posedge clk) disable iff (rst)
        op_valid && is_rot |=> $stable(flag_z) && $stable(flag_dc));

    p_clr_sets_z_r6: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_CLR |=> flag_z);

    p_swap_no_flags_r7: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_SWAP |=> $stable(flag_c) && $stable(flag_dc) && $stable(flag_z));
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .src_sel    (src_sel),
    .dst_sel    (dst_sel),
    .file_rdata (file_rdata),
    .imm_data   (imm_data),
    .w_out      (w_out),
    .flag_c     (flag_c),
    .flag_dc    (flag_dc),
    .flag_z     (flag_z),
    .file_we    (file_we)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic       src_sel = 1'b0;
    logic       dst_sel = 1'b0;
    logic [7:0] file_rdata = 8'h00;
    logic [7:0] imm_data = 8'h00;
    logic [7:0] w_out;
    logic       flag_c, flag_dc, flag_z;
    logic [7:0] file_wdata;
    logic       file_we;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] w_exp = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .src_sel(src_sel), .dst_sel(dst_sel), .file_rdata(file_rdata),
        .imm_data(imm_data), .w_out(w_out), .flag_c(flag_c), .flag_dc(flag_dc),
        .flag_z(flag_z), .file_wdata(file_wdata), .file_we(file_we)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Applies one operation and checks result, flags and strobe timing (R12).
    task automatic run_op(input string req, input logic [3:0] op, input logic src,
                          input logic dst, input logic [7:0] fd, input logic [7:0] imm,
                          input logic [7:0] res, input logic c, input logic dc, input logic z);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; src_sel = src; dst_sel = dst;
        file_rdata = fd; imm_data = imm;
        @(negedge clk);
        op_valid = 1'b0;
        if (!dst) begin
            w_exp = res;
            check({req, " W"}, w_out, w_exp);
            check({req, " R8 no strobe"}, {7'd0, file_we}, 8'd0);
        end else begin
            check({req, " R8 strobe"}, {7'd0, file_we}, 8'd1);
            check({req, " R8 wdata"}, file_wdata, res);
            check({req, " R8 W kept"}, w_out, w_exp);
        end
        check({req, " C"},  {7'd0, flag_c},  {7'd0, c});
        check({req, " DC"}, {7'd0, flag_dc}, {7'd0, dc});
        check({req, " Z"},  {7'd0, flag_z},  {7'd0, z});
        @(negedge clk);
        check({req, " R12 strobe one cycle"}, {7'd0, file_we}, 8'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 W", w_out, 8'h00);
        check("R1 flags", {5'd0, flag_z, flag_dc, flag_c}, 8'h00);
        check("R1 strobe", {7'd0, file_we}, 8'd0);
        rst = 1'b0;
    endtask

    task automatic t_add;
        run_op("R9 R6 pass imm", 4'd5, 1'b1, 1'b0, 8'h00, 8'h3A, 8'h3A, 1'b0, 1'b0, 1'b0);
        run_op("R2 add carry",   4'd0, 1'b1, 1'b0, 8'h00, 8'hC8, 8'h02, 1'b1, 1'b1, 1'b0);
        run_op("R2 add zero",    4'd0, 1'b1, 1'b0, 8'h00, 8'hFE, 8'h00, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_sub;
        run_op("R6 pass imm",    4'd5, 1'b1, 1'b0, 8'h00, 8'h25, 8'h25, 1'b1, 1'b1, 1'b0);
        run_op("R3 sub nibble borrow", 4'd1, 1'b1, 1'b0, 8'h00, 8'h30, 8'h0B, 1'b1, 1'b0, 1'b0);
        run_op("R3 sub borrow",  4'd1, 1'b1, 1'b1, 8'h00, 8'h05, 8'hFA, 1'b0, 1'b0, 1'b0);
        run_op("R3 sub equal",   4'd1, 1'b1, 1'b1, 8'h00, 8'h0B, 8'h00, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_logic;
        run_op("R4 and",  4'd2, 1'b1, 1'b0, 8'h00, 8'hF0, 8'h00, 1'b1, 1'b1, 1'b1);
        run_op("R4 R9 xor file", 4'd4, 1'b0, 1'b0, 8'h5A, 8'hFF, 8'h5A, 1'b1, 1'b1, 1'b0);
        run_op("R4 ior",  4'd3, 1'b1, 1'b1, 8'h00, 8'h81, 8'hDB, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_rotate;
        run_op("R5 rlc",      4'd9,  1'b0, 1'b1, 8'h81, 8'h00, 8'h03, 1'b1, 1'b1, 1'b0);
        run_op("R5 rrc",      4'd10, 1'b0, 1'b1, 8'h02, 8'h00, 8'h81, 1'b0, 1'b1, 1'b0);
        run_op("R5 rlc zero", 4'd9,  1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_unary;
        run_op("R6 inc wrap", 4'd7,  1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1);
        run_op("R6 dec wrap", 4'd8,  1'b1, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
        run_op("R6 com",      4'd6,  1'b0, 1'b1, 8'h0F, 8'h00, 8'hF0, 1'b0, 1'b1, 1'b0);
        run_op("R6 clr",      4'd12, 1'b1, 1'b0, 8'h00, 8'h77, 8'h00, 1'b0, 1'b1, 1'b1);
        run_op("R7 swap",     4'd11, 1'b1, 1'b0, 8'h00, 8'hA5, 8'h5A, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0; src_sel = 1'b1; dst_sel = 1'b0; imm_data = 8'hFF;
        @(negedge clk);
        check("R10 W", w_out, w_exp);
        check("R10 flags", {5'd0, flag_z, flag_dc, flag_c}, 8'b0000_0110);
        check("R10 strobe", {7'd0, file_we}, 8'd0);
        for (int k = 13; k < 16; k++) begin
            op_valid = 1'b1; op_code = k[3:0]; dst_sel = k[0];
            @(negedge clk);
            op_valid = 1'b0;
            check("R11 W", w_out, w_exp);
            check("R11 flags", {5'd0, flag_z, flag_dc, flag_c}, 8'b0000_0110);
            check("R11 strobe", {7'd0, file_we}, 8'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_unary();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule